// File: doc/BRIEF.md
# Three-Multiplier Complex Multiply-Accumulate

This block keeps a running complex sum. Each accepted beat takes two signed complex operands, (P + jQ) and (R + jS), and adds their product to a complex accumulator that holds a real part and an imaginary part. Only three real multiplications are used per beat.

The first multiplication, (P − Q)·S, is shared by both halves of the result. The real half then adds (R − S)·P and the imaginary half adds Q·(R + S). Each of these two products is formed in a multiplier that also takes the present accumulator value as one more addend, so the accumulation needs no adder of its own after the product. The three pre-adder terms are formed from the operands before any multiplication starts. A clear input restarts the sum: with a beat it loads the bare product, and on its own it empties the accumulators.

Arithmetic is two's complement throughout. The accumulators wrap on overflow. The block does no rounding, saturation or scaling.

Top module: `cmac3_top`

## Requirements
- R1: After reset, accRe and accIm are zero and validOut is low.
- R2: On a clock edge with validIn high and clear low, accRe becomes accRe + (P·R − Q·S) and accIm becomes accIm + (P·S + Q·R). Both take their new value on that same edge, and the arithmetic is modulo 2^AW.
- R3: On a clock edge with validIn and clear both high, accRe becomes P·R − Q·S and accIm becomes P·S + Q·R. The earlier sum is discarded.
- R4: On a clock edge with clear high and validIn low, both accumulators become zero, whatever the operand values.
- R5: On a clock edge with validIn and clear both low, both accumulators keep their value, whatever the operand values.
- R6: validOut equals the validIn value sampled at the previous clock edge.
- R7: The result is exact when the operands take their most negative and most positive W-bit values, including the cases where P − Q, R − S or R + S need W+1 bits.
- R8: When the running sum passes the AW-bit signed range, it wraps modulo 2^AW. The default is AW = 2·W + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Restart the accumulators |
| validIn | input | 1 | Operands valid; accumulate this beat |
| opP | input | W | Real part of the first operand, signed |
| opQ | input | W | Imaginary part of the first operand, signed |
| opR | input | W | Real part of the second operand, signed |
| opS | input | W | Imaginary part of the second operand, signed |
| accRe | output | AW | Real accumulator, signed |
| accIm | output | AW | Imaginary accumulator, signed |
| validOut | output | 1 | validIn delayed by one cycle |

## Verification
Long accumulation runs with full-width random operands show whether the shared (P − Q)·S term and the two folded products together rebuild P·R − Q·S and P·S + Q·R. A wrong sign or operand swap in either lane shows up within a few beats. Runs with small-magnitude operands keep the sums near zero, so sign-handling faults show up without wrap hiding them. Directed beats at the extreme W-bit values catch a pre-adder that is one bit too narrow. A long run of maximal products catches an accumulator that saturates or drops the carry instead of wrapping. Random mixes of clear with and without validIn, and of idle beats, tell apart the load, zero and hold behaviours on the edges where each one applies.

// File: rtl/cmac3_pkg.sv
package cmac3_pkg;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic accEn;     // accumulator registers load this edge
    logic baseZero;  // discard the present sum as addend
    logic prodKeep;  // include the complex product in the update
  } cmacStrobe_t;

endpackage

// File: rtl/cmac3_ctrl.sv
module cmac3_ctrl
  import cmac3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        validIn,
  output cmacStrobe_t strobe,
  output logic        validOut
);

  always_comb begin
    strobe.accEn    = validIn | clear;
    strobe.baseZero = clear;
    strobe.prodKeep = validIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/cmac3_mulacc.sv
// Signed multiplier with one extra addend entering as a partial product.
// With the addend tied to zero it serves as a plain multiplier.
module cmac3_mulacc #(
  parameter int IW = 33,
  parameter int OW = 66
) (
  input  logic signed [IW-1:0] opA,
  input  logic signed [IW-1:0] opB,
  input  logic signed [OW-1:0] addend,
  output logic signed [OW-1:0] result
);

  localparam int XW = OW - IW;

  logic signed [OW-1:0] aExt;
  logic signed [OW-1:0] bExt;

  always_comb begin
    aExt   = {{XW{opA[IW-1]}}, opA};
    bExt   = {{XW{opB[IW-1]}}, opB};
    result = aExt * bExt + addend;
  end

endmodule

// File: rtl/cmac3_dp.sv
module cmac3_dp
  import cmac3_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 2 * W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmacStrobe_t         strobe,
  input  logic signed [W-1:0] opP,
  input  logic signed [W-1:0] opQ,
  input  logic signed [W-1:0] opR,
  input  logic signed [W-1:0] opS,
  output logic signed [AW-1:0] accRe,
  output logic signed [AW-1:0] accIm
);

  localparam int EW    = W + 1;
  localparam int LANES = 2;

  logic signed [EW-1:0] pExt, qExt, rExt, sExt;
  logic signed [EW-1:0] diffPQ, diffRS, sumRS;
  logic signed [AW-1:0] sharedProd;

  // Lane 0 is the real part, lane 1 the imaginary part.
  logic signed [EW-1:0] laneA    [LANES];
  logic signed [EW-1:0] laneB    [LANES];
  logic signed [AW-1:0] laneBase [LANES];
  logic signed [AW-1:0] laneMac  [LANES];
  logic signed [AW-1:0] laneNext [LANES];
  logic signed [AW-1:0] accReg   [LANES];

  // Pre-adders, one bit wider than the operands.
  always_comb begin
    pExt   = {opP[W-1], opP};
    qExt   = {opQ[W-1], opQ};
    rExt   = {opR[W-1], opR};
    sExt   = {opS[W-1], opS};
    diffPQ = pExt - qExt;
    diffRS = rExt - sExt;
    sumRS  = rExt + sExt;
  end

  // Shared term (P-Q)*S, plain multiplier.
  cmac3_mulacc #(.IW(EW), .OW(AW)) u_shared (
    .opA    (diffPQ),
    .opB    (sExt),
    .addend ('0),
    .result (sharedProd)
  );

  always_comb begin
    laneA[0] = diffRS;
    laneB[0] = pExt;
    laneA[1] = qExt;
    laneB[1] = sumRS;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    always_comb laneBase[ln] = strobe.baseZero ? '0 : accReg[ln];

    cmac3_mulacc #(.IW(EW), .OW(AW)) u_mac (
      .opA    (laneA[ln]),
      .opB    (laneB[ln]),
      .addend (laneBase[ln]),
      .result (laneMac[ln])
    );

    always_comb laneNext[ln] = strobe.prodKeep ? (laneMac[ln] + sharedProd)
                                               : laneBase[ln];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             accReg[ln] <= '0;
      else if (strobe.accEn) accReg[ln] <= laneNext[ln];
    end
  end

  assign accRe = accReg[0];
  assign accIm = accReg[1];

endmodule

// File: rtl/cmac3_top.sv
module cmac3_top
  import cmac3_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 2 * W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 validIn,
  input  logic signed [W-1:0]  opP,
  input  logic signed [W-1:0]  opQ,
  input  logic signed [W-1:0]  opR,
  input  logic signed [W-1:0]  opS,
  output logic signed [AW-1:0] accRe,
  output logic signed [AW-1:0] accIm,
  output logic                 validOut
);

  cmacStrobe_t strobe;

  cmac3_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  cmac3_dp #(.W(W), .AW(AW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opP    (opP),
    .opQ    (opQ),
    .opR    (opR),
    .opS    (opS),
    .accRe  (accRe),
    .accIm  (accIm)
  );

endmodule

// File: rtl/cmac3_chk.sv
module cmac3_chk #(
  parameter int W  = 32,
  parameter int AW = 2 * W + 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clear,
  input logic                 validIn,
  input logic signed [W-1:0]  opP,
  input logic signed [W-1:0]  opQ,
  input logic signed [W-1:0]  opR,
  input logic signed [W-1:0]  opS,
  input logic signed [AW-1:0] accRe,
  input logic signed [AW-1:0] accIm,
  input logic                 validOut
);

  function automatic logic signed [AW-1:0] sx(input logic signed [W-1:0] v);
    return {{(AW-W){v[W-1]}}, v};
  endfunction

  // Direct four-product reference, independent of the three-product datapath.
  logic signed [AW-1:0] refRe, refIm;
  always_comb begin
    refRe = sx(opP) * sx(opR) - sx(opQ) * sx(opS);
    refIm = sx(opP) * sx(opS) + sx(opQ) * sx(opR);
  end

  AST_RESET_STATE: assert property (@(posedge clk) $rose(rstN) |-> (accRe == '0 && accIm == '0 && !validOut)); // R1
  AST_ACCUM_RE: assert property (@(posedge clk) disable iff (!rstN) (validIn && !clear) |=> accRe == $past(accRe + refRe)); // R2
  AST_ACCUM_IM: assert property (@(posedge clk) disable iff (!rstN) (validIn && !clear) |=> accIm == $past(accIm + refIm)); // R2
  AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (!rstN) (validIn && clear) |=> (accRe == $past(refRe) && accIm == $past(refIm))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN) (clear && !validIn) |=> (accRe == '0 && accIm == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!clear && !validIn) |=> ($stable(accRe) && $stable(accIm))); // R5
  AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rstN) validIn |=> validOut); // R6
  AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rstN) !validIn |=> !validOut); // R6

endmodule

bind cmac3_top cmac3_chk #(.W(W), .AW(AW)) u_cmac3_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clear    (clear),
  .validIn  (validIn),
  .opP      (opP),
  .opQ      (opQ),
  .opR      (opR),
  .opS      (opS),
  .accRe    (accRe),
  .accIm    (accIm),
  .validOut (validOut)
);

// File: tb/cmac3_top_bench.sv
module cmac3_top_bench;

  localparam int W         = 32;
  localparam int AW        = 2 * W + 2;
  localparam int CLK_PER   = 10;
  localparam int WATCHDOG  = 100000;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 clear = 1'b0;
  logic                 validIn = 1'b0;
  logic signed [W-1:0]  opP = '0, opQ = '0, opR = '0, opS = '0;
  logic signed [AW-1:0] accRe, accIm;
  logic                 validOut;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  logic signed [AW-1:0] modelRe = '0, modelIm = '0;

  always #(CLK_PER / 2) clk = ~clk;

  cmac3_top #(.W(W), .AW(AW)) u_cmac3_top (
    .clk, .rstN, .clear, .validIn, .opP, .opQ, .opR, .opS,
    .accRe, .accIm, .validOut
  );

  function automatic logic signed [AW-1:0] sx(input logic signed [W-1:0] v);
    return {{(AW-W){v[W-1]}}, v};
  endfunction

  function automatic logic signed [AW-1:0] prodRe(input logic signed [W-1:0] p, q, r, s);
    return sx(p) * sx(r) - sx(q) * sx(s);
  endfunction

  function automatic logic signed [AW-1:0] prodIm(input logic signed [W-1:0] p, q, r, s);
    return sx(p) * sx(s) + sx(q) * sx(r);
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one beat at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input string tag, input bit v, input bit c,
                      input logic signed [W-1:0] p, q, r, s);
    validIn = v; clear = c; opP = p; opQ = q; opR = r; opS = s;
    @(posedge clk);
    if (c && v) begin
      modelRe = prodRe(p, q, r, s);
      modelIm = prodIm(p, q, r, s);
    end else if (c) begin
      modelRe = '0;
      modelIm = '0;
    end else if (v) begin
      modelRe = modelRe + prodRe(p, q, r, s);
      modelIm = modelIm + prodIm(p, q, r, s);
    end
    @(negedge clk);
    check({tag, " re"}, accRe, modelRe);
    check({tag, " im"}, accIm, modelIm);
    check({tag, " R6 valid"}, {{(AW-1){1'b0}}, validOut}, {{(AW-1){1'b0}}, v});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_c0de);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 re", accRe, '0);
    check("R1 im", accIm, '0);
    check("R1 valid", {{(AW-1){1'b0}}, validOut}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 load, then R2 accumulate with small values
    step("R3 load", 1, 1, 32'sd3, 32'sd4, 32'sd5, -32'sd6);
    step("R2 acc", 1, 0, -32'sd7, 32'sd2, 32'sd1, 32'sd9);
    step("R2 acc", 1, 0, 32'sd100, -32'sd100, 32'sd50, 32'sd25);
    // R5 hold with garbage operands
    step("R5 hold", 0, 0, MAXV, MINV, 32'sd77, -32'sd1);
    step("R5 hold", 0, 0, 32'sd12345, 32'sd1, MINV, MAXV);
    // R4 clear only, operands ignored
    step("R4 clear", 0, 1, MAXV, MAXV, MAXV, MAXV);
    // R7 extreme operands
    step("R7 ext", 1, 1, MINV, MAXV, MINV, MAXV);
    step("R7 ext", 1, 1, MAXV, MINV, MAXV, MINV);
    step("R7 ext", 1, 1, MINV, MINV, MINV, MINV);
    step("R7 ext", 1, 1, MAXV, MINV, MINV, MAXV);
    // R8 wrap: repeat a near-maximal real product
    step("R8 wrap", 1, 1, MINV, MAXV, MINV, MINV);
    for (int k = 0; k < 12; k++) step("R8 wrap", 1, 0, MINV, MAXV, MINV, MINV);

    // Random full-width run
    for (int k = 0; k < 400; k++) begin
      int unsigned mode;
      mode = $urandom % 16;
      step("R2 rand", (mode < 12) || (mode == 14), (mode == 13) || (mode == 14),
           $urandom, $urandom, $urandom, $urandom);
    end
    // Random small-magnitude run
    step("R4 clear", 0, 1, 32'sd0, 32'sd0, 32'sd0, 32'sd0);
    for (int k = 0; k < 300; k++) begin
      int unsigned mode;
      mode = $urandom % 16;
      step("R2 small", mode < 13, mode == 15,
           32'($signed($urandom % 64)) - 32'sd32, 32'($signed($urandom % 64)) - 32'sd32,
           32'($signed($urandom % 64)) - 32'sd32, 32'($signed($urandom % 64)) - 32'sd32);
    end
    finished = 1;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

endmodule